// File: doc/BRIEF.md
# Dispatch Group Former

This block takes a stream of pre-decoded instructions in program order and packs them into dispatch groups of six slots. Slots 0 to 3 carry non-branch work and slots 4 and 5 carry branches. Each instruction arrives with a 3-bit class code. The code tells the packer where the instruction may sit and whether it must open or close a group. When the next instruction cannot legally join the group being built, the packer emits that group, and the instruction becomes the first entry of the following group.

Both sides use a valid/ready handshake. An input is consumed on a clock edge where `in_valid` and `in_ready` are both high. A group is handed off on a clock edge where `out_valid` and `out_ready` are both high.

Back-pressure rules:
- While `out_valid` is high and `out_ready` is low, the emitted group stays frozen and `in_ready` is low.
- On the cycle the group is taken, the next instruction can already be accepted into a fresh group. This gives a rate of one group per cycle.

Two control pins shape group boundaries:
- `in_close` travels with an instruction and closes the group right after that instruction.
- `flush_req` releases a partly filled group, but only in a cycle with no valid input.

Top module: `dgf_group_former`

## Requirements
- R1: After reset, `out_valid` is 0, `out_slot_valid` is 0, and `in_ready` is 1.
- R2: Class code 0 is a branch and may occupy only slots 4 then 5. Codes 1, 6 and 7 are plain ops that fill slots 0 to 3 in order. A group never holds more than 4 non-branch entries or 2 branches.
- R3: A first branch leaves the group open. Accepting a second branch closes the group, and `out_valid` rises on the next cycle.
- R4: Code 2 (lead-only) may occupy only slot 0 of an otherwise empty group. Any open group is emitted before it.
- R5: Code 3 (low-pair) may occupy only slot 0 or slot 1. If slot 1 is already taken, the group is emitted first.
- R6: Code 4 (split) needs an empty group. It takes slots 0 and 1, and both slots carry its payload.
- R7: Code 5 (solo) needs an empty group and takes slots 0 to 3, all carrying its payload. The group then closes at once, so no branch joins it.
- R8: Placement follows program order. An instruction that does not fit causes the current group to close with `in_ready` low. That instruction then starts the next group.
- R9: While `out_valid` is high and `out_ready` is low, `out_slot_valid` and `out_slots` stay unchanged and `in_ready` is low.
- R10: An instruction accepted with `in_close` high is the last entry of its group.
- R11: With no valid input, a non-empty open group is emitted only when `flush_req` is high. An empty group is never emitted.
- R12: Unused slots read as zero payload. Slot i occupies bits [i*PW +: PW] of `out_slots`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_class | input | 3 | Placement class code |
| in_close | input | 1 | Close the group after this instruction |
| in_data | input | PW | Instruction payload |
| flush_req | input | 1 | Release a partial group when no input is offered |
| out_valid | output | 1 | A closed group is presented |
| out_ready | input | 1 | Consumer takes the group |
| out_slot_valid | output | NB_SLOTS+BR_SLOTS | Occupied-slot mask |
| out_slots | output | (NB_SLOTS+BR_SLOTS)*PW | Slot payloads, slot 0 in the low bits |

## Verification
The bench builds the block with four non-branch slots, two branch slots and an 8-bit payload. Each instruction carries a running sequence number, so any misplacement, duplication or reordering shows up directly in the slot contents. With this geometry every closing rule can be reached in sequences of under ten instructions: a full non-branch row, a second branch, a solo op, and a low-pair op arriving after slot 1 is taken. The long random phase adds the unassigned codes and heavy back-pressure.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  localparam int CLS_W = 3;
  localparam logic [CLS_W-1:0] CLS_BRANCH = 3'd0;
  localparam logic [CLS_W-1:0] CLS_PLAIN  = 3'd1;
  localparam logic [CLS_W-1:0] CLS_LEAD   = 3'd2;
  localparam logic [CLS_W-1:0] CLS_PAIRLO = 3'd3;
  localparam logic [CLS_W-1:0] CLS_SPLIT  = 3'd4;
  localparam logic [CLS_W-1:0] CLS_SOLO   = 3'd5;
endpackage

// File: rtl/dgf_fit.sv
module dgf_fit
  import dgf_pkg::*;
#(
  parameter int NB = 4,
  parameter int BR = 2,
  localparam int NS = NB + BR,
  localparam int CW = $clog2(NB + 1),
  localparam int BW = $clog2(BR + 1)
) (
  input  logic [CW-1:0]    nb_cnt,
  input  logic [BW-1:0]    br_cnt,
  input  logic [CLS_W-1:0] cls,
  output logic             ok,
  output logic [NS-1:0]    mask,
  output logic             ends,
  output logic [CW-1:0]    nb_nxt,
  output logic [BW-1:0]    br_nxt
);
  logic empty;

  always_comb begin
    empty  = (nb_cnt == '0) && (br_cnt == '0);
    ok     = 1'b0;
    mask   = '0;
    ends   = 1'b0;
    nb_nxt = nb_cnt;
    br_nxt = br_cnt;
    case (cls)
      CLS_BRANCH: begin
        if (br_cnt < BW'(BR)) begin
          ok = 1'b1;
          mask[NB + int'(br_cnt)] = 1'b1;
          br_nxt = br_cnt + 1'b1;
          ends = (br_cnt == BW'(BR - 1));
        end
      end
      CLS_LEAD: begin
        if (empty) begin
          ok = 1'b1;
          mask[0] = 1'b1;
          nb_nxt = CW'(1);
        end
      end
      CLS_PAIRLO: begin
        if (nb_cnt < CW'(2)) begin
          ok = 1'b1;
          mask[int'(nb_cnt)] = 1'b1;
          nb_nxt = nb_cnt + 1'b1;
        end
      end
      CLS_SPLIT: begin
        if (empty) begin
          ok = 1'b1;
          mask[1:0] = 2'b11;
          nb_nxt = CW'(2);
        end
      end
      CLS_SOLO: begin
        if (empty) begin
          ok = 1'b1;
          mask[NB-1:0] = '1;
          nb_nxt = CW'(NB);
          ends = 1'b1;
        end
      end
      default: begin
        if (nb_cnt < CW'(NB)) begin
          ok = 1'b1;
          mask[int'(nb_cnt)] = 1'b1;
          nb_nxt = nb_cnt + 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/dgf_slots.sv
module dgf_slots #(
  parameter int NS = 6,
  parameter int PW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [NS-1:0]    wr_en,
  input  logic [PW-1:0]    wr_data,
  output logic [NS*PW-1:0] slots
);
  for (genvar g = 0; g < NS; g++) begin : g_slot
    logic [PW-1:0] hold_q;
    always_ff @(posedge clk) begin
      if (rst)           hold_q <= '0;
      else if (wr_en[g]) hold_q <= wr_data;
      else if (clr)      hold_q <= '0;
    end
    assign slots[g*PW +: PW] = hold_q;
  end
endmodule

// File: rtl/dgf_group_former.sv
module dgf_group_former
  import dgf_pkg::*;
#(
  parameter int NB_SLOTS = 4,
  parameter int BR_SLOTS = 2,
  parameter int PW = 8,
  localparam int NSLOT = NB_SLOTS + BR_SLOTS,
  localparam int CW = $clog2(NB_SLOTS + 1),
  localparam int BW = $clog2(BR_SLOTS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [CLS_W-1:0]    in_class,
  input  logic                in_close,
  input  logic [PW-1:0]       in_data,
  input  logic                flush_req,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [NSLOT-1:0]    out_slot_valid,
  output logic [NSLOT*PW-1:0] out_slots
);
  logic             closed_q;
  logic [CW-1:0]    nb_q;
  logic [BW-1:0]    br_q;
  logic [NSLOT-1:0] mask_q;

  logic             leaving;
  logic [CW-1:0]    eff_nb;
  logic [BW-1:0]    eff_br;
  logic             fit_ok, fit_end, take;
  logic [NSLOT-1:0] fit_mask;
  logic [CW-1:0]    fit_nb;
  logic [BW-1:0]    fit_br;

  assign leaving = closed_q && out_ready;
  assign eff_nb  = leaving ? '0 : nb_q;
  assign eff_br  = leaving ? '0 : br_q;

  dgf_fit #(.NB(NB_SLOTS), .BR(BR_SLOTS)) u_fit (
    .nb_cnt (eff_nb),
    .br_cnt (eff_br),
    .cls    (in_class),
    .ok     (fit_ok),
    .mask   (fit_mask),
    .ends   (fit_end),
    .nb_nxt (fit_nb),
    .br_nxt (fit_br)
  );

  assign in_ready = closed_q ? out_ready : fit_ok;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      closed_q <= 1'b0;
      nb_q     <= '0;
      br_q     <= '0;
      mask_q   <= '0;
    end else if (leaving) begin
      closed_q <= take && (fit_end || in_close);
      nb_q     <= take ? fit_nb : '0;
      br_q     <= take ? fit_br : '0;
      mask_q   <= take ? fit_mask : '0;
    end else if (!closed_q) begin
      if (take) begin
        closed_q <= fit_end || in_close;
        nb_q     <= fit_nb;
        br_q     <= fit_br;
        mask_q   <= mask_q | fit_mask;
      end else if (in_valid) begin
        closed_q <= 1'b1;
      end else if (flush_req && (mask_q != '0)) begin
        closed_q <= 1'b1;
      end
    end
  end

  dgf_slots #(.NS(NSLOT), .PW(PW)) u_slots (
    .clk     (clk),
    .rst     (rst),
    .clr     (leaving),
    .wr_en   (take ? fit_mask : '0),
    .wr_data (in_data),
    .slots   (out_slots)
  );

  assign out_valid      = closed_q;
  assign out_slot_valid = mask_q;

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_slot_valid) && $stable(out_slots)));
  // R9
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
  // R3
  second_branch_close_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !out_valid && in_class == CLS_BRANCH && br_q == BW'(BR_SLOTS - 1))
    |=> out_valid);
  // R7
  solo_whole_row_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_class == CLS_SOLO)
    |=> (out_valid && (&out_slot_valid[NB_SLOTS-1:0]) && out_slot_valid[NSLOT-1:NB_SLOTS] == '0));
  // R11
  no_empty_group_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_slot_valid != '0));
endmodule

// File: tb/test_dgf_group_former.sv
module test_dgf_group_former;
  localparam int NB = 4, BR = 2, PW = 8, NS = NB + BR;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, in_valid, in_ready, in_close, flush_req, out_valid, out_ready;
  logic [2:0] in_class;
  logic [PW-1:0] in_data;
  logic [NS-1:0] out_slot_valid;
  logic [NS*PW-1:0] out_slots;

  dgf_group_former #(.NB_SLOTS(NB), .BR_SLOTS(BR), .PW(PW)) i_dgf_group_former (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_close(in_close), .in_data(in_data),
    .flush_req(flush_req), .out_valid(out_valid), .out_ready(out_ready),
    .out_slot_valid(out_slot_valid), .out_slots(out_slots)
  );

  int n_cmp = 0, n_bad = 0;
  int q_cls[$];
  bit q_end[$];
  logic [PW-1:0] q_pay[$];
  logic [PW-1:0] seq = 8'h01;

  bit m_closed = 1'b0;
  int m_nb = 0, m_br = 0;
  bit [NS-1:0] m_mask = '0;
  logic [PW-1:0] m_pay [NS];

  task automatic check(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit m_fits(int c);
    bit empty = (m_nb == 0) && (m_br == 0);
    case (c)
      0: return m_br < BR;
      2: return empty;
      3: return m_nb < 2;
      4: return empty;
      5: return empty;
      default: return m_nb < NB;
    endcase
  endfunction

  task automatic m_clear();
    m_closed = 0; m_nb = 0; m_br = 0; m_mask = '0;
    for (int i = 0; i < NS; i++) m_pay[i] = '0;
  endtask

  task automatic m_place(int c, logic [PW-1:0] p, bit fc);
    case (c)
      0: begin
        m_mask[NB + m_br] = 1; m_pay[NB + m_br] = p; m_br++;
        if (m_br == BR) m_closed = 1;
      end
      4: begin
        m_mask[0] = 1; m_mask[1] = 1; m_pay[0] = p; m_pay[1] = p; m_nb = 2;
      end
      5: begin
        for (int i = 0; i < NB; i++) begin m_mask[i] = 1; m_pay[i] = p; end
        m_nb = NB; m_closed = 1;
      end
      default: begin
        m_mask[m_nb] = 1; m_pay[m_nb] = p; m_nb++;
      end
    endcase
    if (fc) m_closed = 1;
  endtask

  task automatic push(int c, bit e);
    q_cls.push_back(c); q_end.push_back(e); q_pay.push_back(seq); seq++;
  endtask

  task automatic cycle(string req, int rdy_pct, int gap_pct);
    bit exp_rdy, v, fr, orr, fc;
    int c;
    logic [PW-1:0] p;
    logic [NS*PW-1:0] exp_slots;
    @(negedge clk);
    in_valid  = (q_cls.size() > 0) && ($urandom_range(99) >= gap_pct);
    in_class  = (q_cls.size() > 0) ? 3'(q_cls[0]) : 3'd1;
    in_close  = (q_cls.size() > 0) ? q_end[0] : 1'b0;
    in_data   = (q_cls.size() > 0) ? q_pay[0] : '0;
    out_ready = ($urandom_range(99) < rdy_pct);
    flush_req = (q_cls.size() == 0) ? 1'b1 : ($urandom_range(3) == 0);
    #1;
    exp_rdy = m_closed ? out_ready : m_fits(int'(in_class));
    for (int i = 0; i < NS; i++) exp_slots[i*PW +: PW] = m_pay[i];
    check(req, "out_valid", longint'(out_valid), longint'(m_closed));
    check(req, "out_slot_valid", longint'(out_slot_valid), longint'(m_mask));
    check(req, "out_slots", longint'(out_slots), longint'(exp_slots));
    check(m_closed && !out_ready ? "R9" : req, "in_ready", longint'(in_ready), longint'(exp_rdy));
    v = in_valid; fr = flush_req; orr = out_ready; c = int'(in_class); p = in_data; fc = in_close;
    @(posedge clk);
    if (m_closed && orr) begin
      m_clear();
      if (v) m_place(c, p, fc);
    end else if (!m_closed) begin
      if (v) begin
        if (m_fits(c)) m_place(c, p, fc);
        else m_closed = 1;
      end else if (fr && (m_nb > 0 || m_br > 0)) begin
        m_closed = 1;
      end
    end
    if (v && exp_rdy) begin
      void'(q_cls.pop_front()); void'(q_end.pop_front()); void'(q_pay.pop_front());
    end
  endtask

  task automatic run(string req, int rdy_pct, int gap_pct);
    int guard = 0;
    while ((q_cls.size() > 0 || m_nb > 0 || m_br > 0 || m_closed) && guard < 20000) begin
      cycle(req, rdy_pct, gap_pct);
      guard++;
    end
    check(req, "phase drained", longint'(guard < 20000), 1);
    repeat (3) cycle(req, rdy_pct, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_clear();
    rst = 1; in_valid = 0; in_class = 3'd1; in_close = 0; in_data = '0;
    flush_req = 0; out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "out_valid in reset", longint'(out_valid), 0);
    rst = 0;
    #1;
    // R1 reset state
    check("R1", "out_slot_valid", longint'(out_slot_valid), 0);
    check("R1", "in_ready", longint'(in_ready), 1);
    check("R1", "out_valid", longint'(out_valid), 0);

    // R2 slot classes and limits
    push(1, 0); push(0, 0); push(1, 0); push(1, 0); push(1, 0); push(6, 0); push(7, 0);
    run("R2", 100, 0);
    // R3 second branch closes
    push(0, 0); push(0, 0); push(1, 0); push(0, 0); push(1, 0);
    run("R3", 100, 0);
    // R4 lead-only
    push(1, 0); push(2, 0); push(1, 0); push(0, 0); push(2, 0);
    run("R4", 100, 0);
    // R5 low pair
    push(1, 0); push(1, 0); push(3, 0); push(3, 0); push(3, 0); push(3, 0);
    run("R5", 100, 0);
    // R6 split
    push(1, 0); push(4, 0); push(1, 0); push(0, 0); push(4, 0);
    run("R6", 100, 0);
    // R7 solo
    push(0, 0); push(5, 0); push(0, 0); push(5, 0); push(5, 0);
    run("R7", 100, 0);
    // R8 program order, overflow
    for (int i = 0; i < 9; i++) push(1, 0);
    run("R8", 100, 0);
    // R10 forced close
    push(1, 1); push(1, 0); push(0, 1); push(1, 0);
    run("R10", 100, 0);
    // R11 gaps with flush only when idle
    for (int i = 0; i < 60; i++) push(int'($urandom_range(0, 4)), 0);
    run("R11", 80, 60);
    // R9 back-pressure
    for (int i = 0; i < 200; i++) push(int'($urandom_range(0, 7)), $urandom_range(9) == 0);
    run("R9", 25, 10);
    // R12 long random mix
    for (int i = 0; i < 1500; i++) push(int'($urandom_range(0, 7)), $urandom_range(15) == 0);
    run("R12", 70, 20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule